// File: doc/BRIEF.md
# Hot-Swap Bus Join Controller

This block decides when the two segments of a two-wire serial bus (a card-side segment and a backplane-side segment) may be joined by a repeater. It watches two power-good flags, an enable input, and the synchronized clock and data levels of both segments. Its output, `connect`, turns on the repeater's forwarding channels.

After power is good on both supplies and enable is high, the block waits out a fixed settling period. Only then does it look for a safe joining point. That point is either a STOP condition on side A or an unbroken stretch during which all four lines are high. If the bus is busy when the block becomes ready, it keeps waiting until one of these two events occurs. Once joined, the segments stay joined until enable or either power-good flag drops. All timing is counted in clock cycles and set by parameters. A two-bit state output exposes the sequencer position.

Top module: `hotswap_link_ctrl`

## Requirements
- R1: `connect` is low whenever either power-good flag is low, and the two flags may rise in either order. On the clock edge after either flag is seen low, the state is OFF.
- R2: A low `enable` sampled at a clock edge puts the block in OFF at that edge, whatever state it was in.
- R3: When both power-good flags and `enable` are high in OFF, the block enters INIT at the next edge. It stays in INIT for exactly INIT_CYCLES edges and then moves to WATCH.
- R4: STOP and idle detection are armed only in WATCH. Bus events that occur during INIT cannot cause a join.
- R5: In WATCH, the block moves to LINK once all four lines (sdaA, sclA, sdaB, sclB) have been sampled high on IDLE_CYCLES consecutive edges. The count starts with the first WATCH edge. The block never joins on an edge where any line is sampled low.
- R6: A low sample on any of the four lines restarts the idle count. LINK then follows IDLE_CYCLES edges after the edge that saw the low.
- R7: In WATCH, a STOP on side A causes LINK at the edge where it is seen. A STOP is sdaA sampled low then high while sclA is high in both samples, with all four lines high at that edge. A STOP on side B alone causes no join.
- R8: In LINK, bus activity on any line has no effect. The block stays in LINK until `enable` or a power-good flag falls.
- R9: `state` encodes OFF=0, INIT=1, WATCH=2, LINK=3, and `connect` is high exactly when `state` is LINK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset to OFF |
| pwrGoodA | input | 1 | Side A supply good |
| pwrGoodB | input | 1 | Side B supply good |
| enable | input | 1 | Active-high join permission |
| sdaA | input | 1 | Synchronized side A data level |
| sclA | input | 1 | Synchronized side A clock level |
| sdaB | input | 1 | Synchronized side B data level |
| sclB | input | 1 | Synchronized side B clock level |
| connect | output | 1 | Enables the repeater channels |
| state | output | 2 | Sequencer state (OFF=0, INIT=1, WATCH=2, LINK=3) |

## Verification
The embedded properties check the following on every cycle:
- a drop of power or enable forces OFF on the next edge;
- a ready OFF state always advances to INIT;
- no join happens on an edge where a line is low;
- LINK holds while its conditions stay true;
- any low line clears the idle count.

Some behaviour can only be shown by the directed scenarios, because it spans long windows or depends on ordering. This includes the exact length of INIT and of the idle interval, the restart of that interval after a one-cycle glitch, and either order of power-good arrival. It also includes rejection of a STOP seen during INIT or on side B only, and tolerance of bus traffic after the join.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_INIT  = 2'd1,
    ST_WATCH = 2'd2,
    ST_LINK  = 2'd3
  } hscState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic initRun;   // advance settling counter
    logic idleArm;   // allow idle counting and STOP detection
  } hscStrobe_t;

endpackage

// File: rtl/hsc_datapath.sv
module hsc_datapath
  import hsc_pkg::*;
#(
  parameter int INIT_CYCLES = 5000,
  parameter int IDLE_CYCLES = 2500
) (
  input  logic       clk,
  input  logic       rstN,
  input  hscStrobe_t strobe,
  input  logic       sdaA,
  input  logic       sclA,
  input  logic       sdaB,
  input  logic       sclB,
  output logic       initDone,
  output logic       idleDone,
  output logic       stopSeen,
  output logic       allHigh
);

  localparam int INIT_W = $clog2(INIT_CYCLES + 1);
  localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CYCLES - 1);

  logic [INIT_W-1:0] initCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic              sdaAPrev;
  logic              sclAPrev;

  assign allHigh  = sdaA & sclA & sdaB & sclB;
  assign initDone = strobe.initRun && (initCnt == INIT_LAST);
  assign idleDone = strobe.idleArm && allHigh && (idleCnt == IDLE_LAST);
  assign stopSeen = strobe.idleArm && allHigh && !sdaAPrev && sclAPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaAPrev <= 1'b0;
      sclAPrev <= 1'b0;
    end else begin
      sdaAPrev <= sdaA;
      sclAPrev <= sclA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.initRun) begin
      initCnt <= '0;
    end else if (initCnt != INIT_LAST) begin
      initCnt <= initCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.idleArm || !allHigh) begin
      idleCnt <= '0;
    end else if (idleCnt != IDLE_LAST) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // R6: a low line leaves the idle count at zero afterwards
  assert_idle_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    !allHigh |=> (idleCnt == '0));

  // R3: settling counter never passes its terminal value
  assert_init_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    initCnt <= INIT_LAST);

endmodule

// File: rtl/hsc_control.sv
module hsc_control
  import hsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGoodA,
  input  logic       pwrGoodB,
  input  logic       enable,
  input  logic       initDone,
  input  logic       idleDone,
  input  logic       stopSeen,
  input  logic       allHigh,
  output hscStrobe_t strobe,
  output hscState_e  curState
);

  hscState_e nextState;
  logic      ready;

  assign ready = pwrGoodA & pwrGoodB & enable;

  always_comb begin
    nextState = curState;
    if (!ready) begin
      nextState = ST_OFF;
    end else begin
      unique case (curState)
        ST_OFF:   nextState = ST_INIT;
        ST_INIT:  if (initDone) nextState = ST_WATCH;
        ST_WATCH: if (idleDone || stopSeen) nextState = ST_LINK;
        ST_LINK:  nextState = ST_LINK;
        default:  nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= ST_OFF;
    else       curState <= nextState;
  end

  always_comb begin
    strobe.initRun = (curState == ST_INIT);
    strobe.idleArm = (curState == ST_WATCH);
  end

  assert_power_drop_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(pwrGoodA && pwrGoodB) |=> (curState == ST_OFF));

  assert_enable_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (curState == ST_OFF));

  assert_off_to_init_R3: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_OFF && ready) |=> (curState == ST_INIT));

  assert_no_join_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_WATCH && !allHigh) |=> (curState != ST_LINK));

  assert_init_no_join_R4: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_INIT) |=> (curState != ST_LINK));

  assert_link_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_LINK && ready) |=> (curState == ST_LINK));

endmodule

// File: rtl/hotswap_link_ctrl.sv
module hotswap_link_ctrl
  import hsc_pkg::*;
#(
  parameter int INIT_CYCLES = 5000,
  parameter int IDLE_CYCLES = 2500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGoodA,
  input  logic       pwrGoodB,
  input  logic       enable,
  input  logic       sdaA,
  input  logic       sclA,
  input  logic       sdaB,
  input  logic       sclB,
  output logic       connect,
  output logic [1:0] state
);

  hscStrobe_t strobe;
  hscState_e  curState;
  logic       initDone;
  logic       idleDone;
  logic       stopSeen;
  logic       allHigh;

  hsc_datapath #(
    .INIT_CYCLES(INIT_CYCLES),
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sdaA(sdaA), .sclA(sclA), .sdaB(sdaB), .sclB(sclB),
    .initDone(initDone), .idleDone(idleDone),
    .stopSeen(stopSeen), .allHigh(allHigh)
  );

  hsc_control u_control (
    .clk(clk), .rstN(rstN),
    .pwrGoodA(pwrGoodA), .pwrGoodB(pwrGoodB), .enable(enable),
    .initDone(initDone), .idleDone(idleDone),
    .stopSeen(stopSeen), .allHigh(allHigh),
    .strobe(strobe), .curState(curState)
  );

  assign connect = (curState == ST_LINK);
  assign state   = curState;

endmodule

// File: tb/hotswap_link_ctrl_bench.sv
module hotswap_link_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int INIT_N = 20;
  localparam int IDLE_N = 30;

  logic       clk = 1'b0;
  logic       rstN;
  logic       pwrGoodA, pwrGoodB, enable;
  logic       sdaA, sclA, sdaB, sclB;
  logic       connect;
  logic [1:0] state;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hotswap_link_ctrl #(.INIT_CYCLES(INIT_N), .IDLE_CYCLES(IDLE_N)) u_hotswap_link_ctrl (
    .clk(clk), .rstN(rstN), .pwrGoodA(pwrGoodA), .pwrGoodB(pwrGoodB),
    .enable(enable), .sdaA(sdaA), .sclA(sclA), .sdaB(sdaB), .sclB(sclB),
    .connect(connect), .state(state)
  );

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkState(input string req, input int exp);
    chk(req, int'(state), exp);
    chk(req, int'(connect), (exp == 3) ? 1 : 0);
  endtask

  task automatic busIdle();
    sdaA = 1; sclA = 1; sdaB = 1; sclB = 1;
  endtask

  task automatic testReset();
    chkState("R9 reset", 0);
  endtask

  task automatic testPowerOrderAndIdle();
    busIdle();
    enable = 1; pwrGoodA = 1; pwrGoodB = 0;
    tick(10);
    chkState("R1 only A good", 0);
    pwrGoodB = 1;
    tick(1);
    chkState("R3 enter init", 1);
    tick(INIT_N - 1);
    chkState("R3 init not yet over", 1);
    tick(1);
    chkState("R3 init length", 2);
    tick(IDLE_N - 1);
    chkState("R5 idle not yet full", 2);
    tick(1);
    chkState("R5 idle join", 3);
    sdaA = 0; sclB = 0;
    tick(5);
    sclA = 0; sdaB = 0;
    tick(3);
    chkState("R8 traffic keeps link", 3);
    busIdle();
  endtask

  task automatic testEnableDrop();
    enable = 0;
    tick(1);
    chkState("R2 drop in link", 0);
    enable = 1;
    tick(4);
    enable = 0;
    tick(1);
    chkState("R2 drop in init", 0);
  endtask

  task automatic testIdleRestart();
    busIdle();
    enable = 1;
    tick(1 + INIT_N);
    chkState("R6 in watch", 2);
    tick(IDLE_N - 5);
    sclB = 0;
    tick(1);
    sclB = 1;
    tick(IDLE_N - 1);
    chkState("R6 restart holds off", 2);
    tick(1);
    chkState("R6 join after restart", 3);
    enable = 0;
    tick(1);
  endtask

  task automatic testStop();
    busIdle();
    sdaA = 0;
    enable = 1;
    tick(1);
    chkState("R3 re-enter init", 1);
    tick(5);
    sdaA = 1;
    tick(1);
    chkState("R4 stop during init ignored", 1);
    sdaA = 0;
    tick(INIT_N - 6);
    chkState("R4 watch after init", 2);
    tick(IDLE_N + 10);
    chkState("R5 busy line blocks join", 2);
    sdaA = 1; sdaB = 0;
    tick(3);
    sdaB = 1;
    tick(1);
    chkState("R7 side B stop ignored", 2);
    sdaA = 0;
    tick(3);
    sdaA = 1;
    tick(1);
    chkState("R7 side A stop joins", 3);
  endtask

  task automatic testPowerDrop();
    pwrGoodB = 0;
    tick(1);
    chkState("R1 B drop in link", 0);
    tick(5);
    chkState("R1 stays off", 0);
    pwrGoodB = 1;
    tick(1);
    chkState("R3 power return", 1);
    pwrGoodA = 0;
    tick(1);
    chkState("R1 A drop in init", 0);
    pwrGoodB = 0;
    tick(2);
    pwrGoodA = 1;
    tick(3);
    chkState("R1 only A back", 0);
    pwrGoodB = 1;
    tick(1);
    chkState("R3 B last", 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 0;
    pwrGoodA = 0; pwrGoodB = 0; enable = 0;
    sdaA = 0; sclA = 0; sdaB = 0; sclB = 0;
    tick(3);
    rstN = 1;
    tick(1);
    testReset();
    testPowerOrderAndIdle();
    testEnableDrop();
    testIdleRestart();
    testStop();
    testPowerDrop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule